// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block is a true dual-port synchronous memory. Its two ports share one storage array of 16 384 data bits and 2 048 parity bits. Each port has its own clock, enable, write enable, synchronous output set/reset, address, write data, write parity, read data and read parity. The total width of each port, counting parity, is set by a parameter at build time from the set 1, 2, 4, 9, 18 and 36. The two choices are independent, so one port can address the array as many narrow locations while the other sees it as fewer wide words.

Internally the array is held as two banks. Each bank is written only by one port's clock, and the two are combined by exclusive-or on every read. A narrow location is one lane of a 36-bit internal word. Data lanes and parity lanes are selected separately from the low address bits. Each control input, and each clock, can be inverted by a parameter. The output registers load a per-port set/reset value. Typical use is a width-converting buffer between two clock domains, for example a byte-plus-parity producer feeding a 32-bit consumer.

Top module: `dpram_mixed`

## Requirements
- R1: While rst_n is low, and after it rises until that port's first enabled edge, each port's data output shows the low data-width bits of its set/reset value. Its parity output shows the next parity-count bits of that value, and the remaining parity output bits are 0.
- R2: A port's parity count is 0 for widths 1, 2 and 4, 1 for 9, 2 for 18 and 4 for 36. Its data width is the total width minus the parity count. Its address width is 14 minus log2 of the data width, so every location up to the highest address is usable.
- R3: Internal word number = address shifted right by log2(32 / data width). Lane = the low bits that are shifted out. The data lane occupies data bits [lane*dw +: dw] of the word, and the parity lane occupies parity bits [lane*pw +: pw], with data and parity kept as separate lanes.
- R4: Memory is written on an active clock edge only when both that port's enable and write enable are active. Otherwise no stored bit changes.
- R5: An enabled edge with write enable and set/reset both inactive loads the addressed data and parity into the output registers. The value is visible after that edge.
- R6: An enabled write edge without set/reset also places the written data and parity on that port's outputs (write-first).
- R7: An edge with the port's enable inactive leaves that port's outputs unchanged.
- R8: An enabled edge with set/reset active loads the set/reset value into the outputs. A write on that edge still stores its data, and no other stored bit changes.
- R9: Parameters invert the polarity of each port's clock, enable, write enable and set/reset independently. With the enable inverted, a high level disables the port.
- R10: A read on one port on the same edge as a write to the same bits by the other port returns the data stored before that edge.
- R11: Writes from both ports on the same edge to disjoint bits both land. Writes to the same bits on the same edge give an undefined result.
- R12: Parity input bits above a port's parity count are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released per port synchronously |
| clk_a | input | 1 | Port A clock (polarity set by INV_CLK_A) |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| ssr_a | input | 1 | Port A output set/reset |
| addr_a | input | addr_bits(WIDTH_A) | Port A address |
| din_a | input | dat_bits(WIDTH_A) | Port A write data |
| dpin_a | input | 4 | Port A write parity, low bits used |
| dout_a | output | dat_bits(WIDTH_A) | Port A read data |
| dpout_a | output | 4 | Port A read parity, upper bits zero |
| clk_b | input | 1 | Port B clock (polarity set by INV_CLK_B) |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| ssr_b | input | 1 | Port B output set/reset |
| addr_b | input | addr_bits(WIDTH_B) | Port B address |
| din_b | input | dat_bits(WIDTH_B) | Port B write data |
| dpin_b | input | 4 | Port B write parity, low bits used |
| dout_b | output | dat_bits(WIDTH_B) | Port B read data |
| dpout_b | output | 4 | Port B read parity, upper bits zero |

## Verification
A wrong lane shift or mask in a port controller does not show on the writing port, because write-first echoes its own input. It shows as misplaced bytes or parity bits when the other port, at its different width, reads that word. That happens one edge after the read is issued. Corruption in either bank, or a wrong exclusive-or code, flips bits on both ports at the next read of the affected word, and the full-array fill followed by mixed random traffic reaches every word. Hold, set/reset and write-first faults appear on the output registers the cycle after the offending edge.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  localparam int DATA_W  = 32;
  localparam int PAR_W   = 4;
  localparam int LANE_W  = DATA_W + PAR_W;
  localparam int WORDS   = 512;
  localparam int WORD_AW = $clog2(WORDS);

  function automatic int par_bits(input int total_w);
    case (total_w)
      36:      return 4;
      18:      return 2;
      9:       return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int dat_bits(input int total_w);
    return total_w - par_bits(total_w);
  endfunction

  function automatic int addr_bits(input int total_w);
    return WORD_AW + $clog2(DATA_W) - $clog2(dat_bits(total_w));
  endfunction

endpackage

// File: rtl/dpram_bank.sv
module dpram_bank
  import dpram_pkg::*;
#(
  parameter int DEPTH = WORDS,
  parameter int WW    = LANE_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [WW-1:0] wr_mask,
  input  logic [WW-1:0] wr_code,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [WW-1:0] rd_word_a,
  output logic [WW-1:0] rd_word_b
);

  logic [WW-1:0] store [DEPTH];
  logic [WW-1:0] merged;

  always_comb begin
    merged = (store[wr_addr] & ~wr_mask) | (wr_code & wr_mask);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_addr] <= merged;
    end
  end

  assign rd_word_a = store[rd_addr_a];
  assign rd_word_b = store[rd_addr_b];

endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int              WIDTH   = 9,
  parameter bit              INV_CLK = 1'b0,
  parameter bit              INV_EN  = 1'b0,
  parameter bit              INV_WE  = 1'b0,
  parameter bit              INV_SSR = 1'b0,
  parameter logic [LANE_W-1:0] SRVAL = '0,
  localparam int DW = dat_bits(WIDTH),
  localparam int PW = par_bits(WIDTH),
  localparam int AW = addr_bits(WIDTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               we,
  input  logic               ssr,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      din,
  input  logic [PAR_W-1:0]   dpin,
  output logic [DW-1:0]      dout,
  output logic [PAR_W-1:0]   dpout,
  output logic               clk_eff,
  output logic               wr_fire,
  output logic [WORD_AW-1:0] word_addr,
  output logic [LANE_W-1:0]  wr_mask,
  output logic [LANE_W-1:0]  wr_data,
  input  logic [LANE_W-1:0]  rd_word
);

  localparam int SUB_BITS = AW - WORD_AW;
  localparam logic [DATA_W-1:0] DMASK0 = DATA_W'((33'd1 << DW) - 33'd1);
  localparam logic [PAR_W-1:0]  PMASK0 = PAR_W'((5'd1 << PW) - 5'd1);
  localparam logic [DW-1:0]     SR_D   = SRVAL[DW-1:0];
  localparam logic [PAR_W-1:0]  SR_P   = PAR_W'(SRVAL >> DW) & PMASK0;

  logic en_eff, we_eff, ssr_eff;
  logic [1:0] rst_pipe;
  logic rst_ok;
  logic [4:0] sub;
  int unsigned shamt_d, shamt_p;
  logic [DATA_W-1:0] dmask, dval;
  logic [PAR_W-1:0]  pmask, pval, pin_used;
  logic [DW-1:0]     rd_d;
  logic [PAR_W-1:0]  rd_p;
  logic [DW-1:0]     d_q, d_nxt;
  logic [PAR_W-1:0]  p_q, p_nxt;

  // polarity selection
  assign clk_eff = clk ^ INV_CLK;
  assign en_eff  = en ^ INV_EN;
  assign we_eff  = we ^ INV_WE;
  assign ssr_eff = ssr ^ INV_SSR;

  // reset: asserted asynchronously, released on this port's clock
  always_ff @(posedge clk_eff or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ok = rst_pipe[1];

  // address split into word and lane
  generate
    if (SUB_BITS > 0) begin : g_lane
      assign sub = 5'(addr[SUB_BITS-1:0]);
    end else begin : g_full
      assign sub = '0;
    end
  endgenerate
  assign word_addr = addr[AW-1:SUB_BITS];

  always_comb begin
    shamt_d  = 32'(sub) * DW;
    shamt_p  = 32'(sub) * PW;
    pin_used = dpin & PMASK0;
    dmask    = DMASK0 << shamt_d;
    dval     = DATA_W'(din) << shamt_d;
    pmask    = PMASK0 << shamt_p;
    pval     = pin_used << shamt_p;
    wr_mask  = {pmask, dmask};
    wr_data  = {pval, dval};
    wr_fire  = en_eff & we_eff & rst_ok;
    rd_d     = DW'(rd_word[DATA_W-1:0] >> shamt_d);
    rd_p     = (rd_word[LANE_W-1:DATA_W] >> shamt_p) & PMASK0;
  end

  // output register next state
  always_comb begin
    d_nxt = d_q;
    p_nxt = p_q;
    if (en_eff && rst_ok) begin
      if (ssr_eff) begin
        d_nxt = SR_D;
        p_nxt = SR_P;
      end else if (we_eff) begin
        d_nxt = din;
        p_nxt = pin_used;
      end else begin
        d_nxt = rd_d;
        p_nxt = rd_p;
      end
    end
  end

  always_ff @(posedge clk_eff or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= SR_D;
      p_q <= SR_P;
    end else begin
      d_q <= d_nxt;
      p_q <= p_nxt;
    end
  end

  assign dout  = d_q;
  assign dpout = p_q;

  a_r7_hold_when_off: assert property (@(posedge clk_eff) disable iff (!rst_ok)
    !en_eff |=> $stable({dout, dpout}));

  a_r6_write_first: assert property (@(posedge clk_eff) disable iff (!rst_ok)
    (en_eff && we_eff && !ssr_eff) |=> (dout == $past(din)) && (dpout == ($past(dpin) & PMASK0)));

  a_r8_setreset_value: assert property (@(posedge clk_eff) disable iff (!rst_ok)
    (en_eff && ssr_eff) |=> (dout == SR_D) && (dpout == SR_P));

  a_r5_read_loads: assert property (@(posedge clk_eff) disable iff (!rst_ok)
    (en_eff && !we_eff && !ssr_eff) |=> (dout == $past(rd_d)) && (dpout == $past(rd_p)));

endmodule

// File: rtl/dpram_mixed.sv
module dpram_mixed
  import dpram_pkg::*;
#(
  parameter int                WIDTH_A   = 9,
  parameter int                WIDTH_B   = 36,
  parameter bit                INV_CLK_A = 1'b0,
  parameter bit                INV_EN_A  = 1'b0,
  parameter bit                INV_WE_A  = 1'b0,
  parameter bit                INV_SSR_A = 1'b0,
  parameter bit                INV_CLK_B = 1'b0,
  parameter bit                INV_EN_B  = 1'b0,
  parameter bit                INV_WE_B  = 1'b0,
  parameter bit                INV_SSR_B = 1'b0,
  parameter logic [LANE_W-1:0] SRVAL_A   = '0,
  parameter logic [LANE_W-1:0] SRVAL_B   = '0
) (
  input  logic                                rst_n,
  input  logic                                clk_a,
  input  logic                                en_a,
  input  logic                                we_a,
  input  logic                                ssr_a,
  input  logic [addr_bits(WIDTH_A)-1:0]       addr_a,
  input  logic [dat_bits(WIDTH_A)-1:0]        din_a,
  input  logic [PAR_W-1:0]                    dpin_a,
  output logic [dat_bits(WIDTH_A)-1:0]        dout_a,
  output logic [PAR_W-1:0]                    dpout_a,
  input  logic                                clk_b,
  input  logic                                en_b,
  input  logic                                we_b,
  input  logic                                ssr_b,
  input  logic [addr_bits(WIDTH_B)-1:0]       addr_b,
  input  logic [dat_bits(WIDTH_B)-1:0]        din_b,
  input  logic [PAR_W-1:0]                    dpin_b,
  output logic [dat_bits(WIDTH_B)-1:0]        dout_b,
  output logic [PAR_W-1:0]                    dpout_b
);

  logic               ck_a, ck_b, fire_a, fire_b;
  logic [WORD_AW-1:0] wa_word, wb_word;
  logic [LANE_W-1:0]  mask_a, mask_b, data_a, data_b;
  logic [LANE_W-1:0]  x_at_a, x_at_b, y_at_a, y_at_b;
  logic [LANE_W-1:0]  view_a, view_b, code_a, code_b;

  dpram_port #(
    .WIDTH(WIDTH_A), .INV_CLK(INV_CLK_A), .INV_EN(INV_EN_A),
    .INV_WE(INV_WE_A), .INV_SSR(INV_SSR_A), .SRVAL(SRVAL_A)
  ) u_port_a (
    .clk(clk_a), .rst_n(rst_n), .en(en_a), .we(we_a), .ssr(ssr_a),
    .addr(addr_a), .din(din_a), .dpin(dpin_a), .dout(dout_a), .dpout(dpout_a),
    .clk_eff(ck_a), .wr_fire(fire_a), .word_addr(wa_word),
    .wr_mask(mask_a), .wr_data(data_a), .rd_word(view_a)
  );

  dpram_port #(
    .WIDTH(WIDTH_B), .INV_CLK(INV_CLK_B), .INV_EN(INV_EN_B),
    .INV_WE(INV_WE_B), .INV_SSR(INV_SSR_B), .SRVAL(SRVAL_B)
  ) u_port_b (
    .clk(clk_b), .rst_n(rst_n), .en(en_b), .we(we_b), .ssr(ssr_b),
    .addr(addr_b), .din(din_b), .dpin(dpin_b), .dout(dout_b), .dpout(dpout_b),
    .clk_eff(ck_b), .wr_fire(fire_b), .word_addr(wb_word),
    .wr_mask(mask_b), .wr_data(data_b), .rd_word(view_b)
  );

  // bank X is written only by port A, bank Y only by port B
  assign code_a = data_a ^ y_at_a;
  assign code_b = data_b ^ x_at_b;
  assign view_a = x_at_a ^ y_at_a;
  assign view_b = x_at_b ^ y_at_b;

  dpram_bank u_bank_x (
    .clk(ck_a), .wr_en(fire_a), .wr_addr(wa_word), .wr_mask(mask_a), .wr_code(code_a),
    .rd_addr_a(wa_word), .rd_addr_b(wb_word), .rd_word_a(x_at_a), .rd_word_b(x_at_b)
  );

  dpram_bank u_bank_y (
    .clk(ck_b), .wr_en(fire_b), .wr_addr(wb_word), .wr_mask(mask_b), .wr_code(code_b),
    .rd_addr_a(wa_word), .rd_addr_b(wb_word), .rd_word_a(y_at_a), .rd_word_b(y_at_b)
  );

endmodule

// File: tb/sim_dpram_mixed.sv
module sim_dpram_mixed;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        en_a, we_a, ssr_a, en_b, we_b, ssr_b;
  logic [10:0] addr_a;
  logic [7:0]  din_a, dout_a;
  logic [3:0]  dpin_a, dpout_a, dpin_b, dpout_b;
  logic [8:0]  addr_b;
  logic [31:0] din_b, dout_b;

  dpram_mixed #(
    .WIDTH_A(9), .WIDTH_B(36), .INV_EN_B(1'b1),
    .SRVAL_A(36'h155), .SRVAL_B(36'h912345678)
  ) u0 (
    .rst_n(rst_n),
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a), .addr_a(addr_a),
    .din_a(din_a), .dpin_a(dpin_a), .dout_a(dout_a), .dpout_a(dpout_a),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b), .addr_b(addr_b),
    .din_b(din_b), .dpin_b(dpin_b), .dout_b(dout_b), .dpout_b(dpout_b)
  );

  typedef struct {
    bit          port;
    logic [31:0] d;
    logic [3:0]  p;
    string       req;
    int unsigned due;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  int unsigned cyc = 0;
  bit done = 1'b0;
  logic [16383:0] md;
  logic [2047:0]  mp;
  logic [7:0]  la_d;
  logic [3:0]  la_p, lb_p;
  logic [31:0] lb_d;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // monitor: compares outputs against queued expectations
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      if (e.port == 1'b0) check({e.req, " portA"}, {dpout_a, 24'h0, dout_a}, {e.p, e.d});
      else                check({e.req, " portB"}, {dpout_b, dout_b}, {e.p, e.d});
    end
  end

  // driver: one cycle of stimulus on both ports, called at a falling edge
  task automatic step(input bit ea, input bit wa, input bit sa, input logic [10:0] aa,
                      input logic [7:0] da, input logic pa,
                      input bit eb, input bit wb, input bit sb, input logic [8:0] ab,
                      input logic [31:0] db, input logic [3:0] pb, input string req);
    exp_t e;
    int ia, ipa, ib, ipb;
    ia  = int'(aa[10:2]) * 32 + int'(aa[1:0]) * 8;
    ipa = int'(aa[10:2]) * 4 + int'(aa[1:0]);
    ib  = int'(ab) * 32;
    ipb = int'(ab) * 4;
    en_a = ea; we_a = wa; ssr_a = sa; addr_a = aa; din_a = da; dpin_a = {3'b101, pa};
    en_b = ~eb; we_b = wb; ssr_b = sb; addr_b = ab; din_b = db; dpin_b = pb;
    // expectations from pre-edge contents (R10: old data on cross-port read)
    if (ea) begin
      if (sa)      begin la_d = 8'h55; la_p = 4'h1; end
      else if (wa) begin la_d = da; la_p = {3'b000, pa}; end
      else         begin la_d = md[ia +: 8]; la_p = {3'b000, mp[ipa]}; end
    end
    if (eb) begin
      if (sb)      begin lb_d = 32'h12345678; lb_p = 4'h9; end
      else if (wb) begin lb_d = db; lb_p = pb; end
      else         begin lb_d = md[ib +: 32]; lb_p = mp[ipb +: 4]; end
    end
    if (ea && wa) begin md[ia +: 8] = da; mp[ipa] = pa; end
    if (eb && wb) begin md[ib +: 32] = db; mp[ipb +: 4] = pb; end
    e.port = 1'b0; e.d = {24'h0, la_d}; e.p = la_p; e.req = req; e.due = cyc + 1;
    q.push_back(e);
    e.port = 1'b1; e.d = lb_d; e.p = lb_p;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic a_op(input bit wa, input bit sa, input logic [10:0] aa,
                      input logic [7:0] da, input logic pa, input string req);
    step(1'b1, wa, sa, aa, da, pa, 1'b0, 1'b0, 1'b0, 9'd0, 32'd0, 4'd0, req);
  endtask

  task automatic b_op(input bit wb, input bit sb, input logic [8:0] ab,
                      input logic [31:0] db, input logic [3:0] pb, input string req);
    step(1'b0, 1'b0, 1'b0, 11'd0, 8'd0, 1'b0, 1'b1, wb, sb, ab, db, pb, req);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en_a = 1'b0; we_a = 1'b0; ssr_a = 1'b0; addr_a = '0; din_a = '0; dpin_a = '0;
    en_b = 1'b1; we_b = 1'b0; ssr_b = 1'b0; addr_b = '0; din_b = '0; dpin_b = '0;
    repeat (3) @(negedge clk);
    // R1: set/reset value during reset, parity split after data bits
    check("R1 reset A", {dpout_a, 24'h0, dout_a}, {4'h1, 24'h0, 8'h55});
    check("R1 reset B", {dpout_b, dout_b}, {4'h9, 32'h12345678});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release A", {dpout_a, 24'h0, dout_a}, {4'h1, 24'h0, 8'h55});
    check("R1 after release B", {dpout_b, dout_b}, {4'h9, 32'h12345678});
    la_d = 8'h55; la_p = 4'h1; lb_d = 32'h12345678; lb_p = 4'h9;

    // fill the whole array through the wide port
    for (int w = 0; w < 512; w++) begin
      b_op(1'b1, 1'b0, 9'(w), 32'hA5000000 ^ (32'(w) * 32'h00010203), 4'(w), "R6 fill");
    end

    // R3: wide write, narrow reads of each lane (data and parity lanes)
    b_op(1'b1, 1'b0, 9'd5, 32'h44332211, 4'b1010, "R6 wide write");
    for (int k = 0; k < 4; k++) a_op(1'b0, 1'b0, 11'(20 + k), 8'h00, 1'b0, "R3 narrow lane read");

    // R3 / R12: narrow writes with junk in unused parity inputs, wide read
    a_op(1'b1, 1'b0, 11'd40, 8'hC1, 1'b1, "R12 narrow write");
    a_op(1'b1, 1'b0, 11'd41, 8'hC2, 1'b0, "R6 narrow write");
    a_op(1'b1, 1'b0, 11'd43, 8'hC4, 1'b1, "R6 narrow write");
    b_op(1'b0, 1'b0, 9'd10, 32'd0, 4'd0, "R3 wide read of lanes");

    // R4 / R7: write enable with port disabled: no write, output held
    step(1'b0, 1'b1, 1'b0, 11'd40, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 32'd0, 4'd0, "R7 hold");
    a_op(1'b0, 1'b0, 11'd40, 8'h00, 1'b0, "R4 disabled write ignored");

    // R8: set/reset, memory intact; set/reset with write still stores
    a_op(1'b0, 1'b1, 11'd41, 8'h00, 1'b0, "R8 set/reset");
    a_op(1'b0, 1'b0, 11'd41, 8'h00, 1'b0, "R8 contents kept");
    a_op(1'b1, 1'b1, 11'd42, 8'h77, 1'b1, "R8 reset with write");
    a_op(1'b0, 1'b0, 11'd42, 8'h00, 1'b0, "R8 write landed");
    b_op(1'b0, 1'b1, 9'd3, 32'd0, 4'd0, "R8 set/reset B");
    b_op(1'b0, 1'b0, 9'd3, 32'd0, 4'd0, "R8 contents kept B");

    // R9: B enable is active low; high level disables B
    en_a = 1'b0; we_a = 1'b0; en_b = 1'b1; we_b = 1'b1; addr_b = 9'd7;
    din_b = 32'hDEADBEEF; dpin_b = 4'hF;
    @(negedge clk);
    check("R9 inverted enable holds", {dpout_b, dout_b}, {lb_p, lb_d});
    b_op(1'b0, 1'b0, 9'd7, 32'd0, 4'd0, "R9 inverted enable blocked write");

    // R10: same-edge write on A, read of that word on B
    step(1'b1, 1'b1, 1'b0, 11'd44, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 9'd11, 32'd0, 4'd0, "R10 old data");
    b_op(1'b0, 1'b0, 9'd11, 32'd0, 4'd0, "R10 new data after");

    // R11: both ports write disjoint words on one edge
    step(1'b1, 1'b1, 1'b0, 11'd80, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, 9'd21, 32'h0BADF00D, 4'h6, "R11 dual write");
    a_op(1'b0, 1'b0, 11'd84, 8'h00, 1'b0, "R11 A sees B write");
    b_op(1'b0, 1'b0, 9'd20, 32'd0, 4'd0, "R11 B sees A write");

    // R2: highest narrow address maps to top lane of top word
    a_op(1'b1, 1'b0, 11'd2047, 8'hE7, 1'b1, "R2 top address write");
    b_op(1'b0, 1'b0, 9'd511, 32'd0, 4'd0, "R2 top word read");
    a_op(1'b0, 1'b0, 11'd2044, 8'h00, 1'b0, "R5 lane0 of top word");

    // mixed random traffic, no same-word dual writes
    for (int n = 0; n < 600; n++) begin
      logic [10:0] ra;
      logic [8:0]  rb;
      bit ea, wa, sa, eb, wb, sb;
      ra = 11'($urandom); rb = 9'($urandom);
      ea = ($urandom % 4) != 0; wa = ($urandom % 3) == 0; sa = ($urandom % 16) == 0;
      eb = ($urandom % 4) != 0; wb = ($urandom % 3) == 0; sb = ($urandom % 16) == 0;
      if (ea && wa && eb && wb && ra[10:2] == rb) wb = 1'b0;
      step(ea, wa, sa, ra, 8'($urandom), 1'($urandom), eb, wb, sb, rb, $urandom,
           4'($urandom), "R5 mixed traffic");
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule